// File: doc/BRIEF.md
# Wraparound DMA channel sequencer

This block is a single-channel byte mover. When its enable rises with a nonzero byte count, it copies the base source address, base destination address and count into working registers. It then loops between two phases. In the first it asks the source port for one byte. In the second it offers that byte to the destination port. Each port has a valid/ready handshake, and a one-byte holding register sits between them. Each address register steps on its own, chosen per side: it can increment, hold still, or increment and then snap back to its base.

If either side is set to the wrap code, the channel never finishes by itself. At the end of each pass it reloads both addresses and the count from the base inputs and starts the next pass at once. This repeats until the enable is taken away. Two sticky, write-1-to-clear flags report the midpoint and the end of each pass. Each flag is gated by its own bit of a 4-bit select field, and together they drive one interrupt line. A self-timed soft reset returns the sequencer and its pointers to rest and leaves the configuration inputs alone.

Top module: `dma_wrap_channel`

## Requirements
- R1: After reset the channel is idle: busy, done, rd_valid, wr_valid, irq and swrst_active are all 0. A rising edge of cfg_enable with cfg_count nonzero starts a run from the base inputs. A rising edge with cfg_count equal to 0 is ignored, and the channel stays idle.
- R2: Address modes are a 2-bit code per side. 2'b00 and the reserved 2'b01 add 1 to the address per byte moved, modulo 2^AW. 2'b10 keeps the address constant. 2'b11 adds 1 per byte and returns to the base at the start of each pass.
- R3: Every byte is read at the current source address and written unchanged at the current destination address. While rd_valid is high and rd_ready is low, rd_valid stays high and rd_addr stays the same.
- R4: When neither side uses code 2'b11, the channel stops after exactly cfg_count bytes. It drops busy and raises done for a single cycle, and neither interrupt flag is set.
- R5: When either side uses code 2'b11, after cfg_count bytes both addresses and the count reload from the base inputs. The next pass follows with no change of cfg_enable, and done stays 0.
- R6: With select bit 2 set, half_flag is set in wrap operation once floor(cfg_count/2) bytes of a pass have been written (a count of 32 sets it after 16 bytes). With select bit 2 clear, half_flag is not set.
- R7: With select bit 0 set, wrap_flag is set when the last byte of a wrap-operation pass is written (a count of 32 sets it after 32 bytes). It is never set outside wrap operation.
- R8: Both flags stay set until a one-cycle pulse on their own clear input. A new event in the same cycle wins over the clear. irq is high exactly when (half_flag and select bit 2) or (wrap_flag and select bit 0).
- R9: If cfg_enable falls while a read is waiting, that read still completes with rd_valid held. If cfg_enable falls after a byte has been captured, the byte is dropped with no write. In both cases busy then falls and done stays 0.
- R10: A one-cycle pulse on swrst_set makes swrst_active read 1 for exactly 3 cycles, then 0. The channel is idle from the next cycle on. It does not restart until cfg_enable rises again, and it then begins at the unchanged base addresses.
- R11: rd_from_periph is 1 only for direction code 2'b01, and wr_to_periph is 1 only for direction code 2'b10. Codes 2'b00 and 2'b11 drive both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_enable | input | 1 | Channel enable; a rising edge starts a run, a low level stops it |
| cfg_src_base | input | AW | Base source address |
| cfg_dst_base | input | AW | Base destination address |
| cfg_count | input | CW | Bytes per pass |
| cfg_src_mode | input | 2 | Source address mode code |
| cfg_dst_mode | input | 2 | Destination address mode code |
| cfg_dir | input | 2 | Direction code |
| cfg_irq_sel | input | 4 | Interrupt select; bit 2 midpoint, bit 0 end of pass |
| swrst_set | input | 1 | One-cycle strobe that starts a soft reset |
| clr_half | input | 1 | One-cycle clear for half_flag |
| clr_wrap | input | 1 | One-cycle clear for wrap_flag |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | AW | Read address |
| rd_ready | input | 1 | Source accepts the request; rd_data is valid in that cycle |
| rd_data | input | DW | Read data |
| rd_from_periph | output | 1 | Source side is a peripheral |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_ready | input | 1 | Destination accepts the write |
| wr_to_periph | output | 1 | Destination side is a peripheral |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| swrst_active | output | 1 | Soft reset in progress |
| half_flag | output | 1 | Sticky midpoint flag |
| wrap_flag | output | 1 | Sticky end-of-pass flag |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take swrst_set, clr_half and clr_wrap to be single-cycle strobes. They assume the base, count and mode inputs stay put while a run is active, so each address step and each midpoint compare sees the configuration that started the pass. The bench therefore changes configuration only while the channel is idle. The one exception is the select field, which is changed mid-run on purpose to check the gating. Ready inputs follow arbitrary 8-cycle patterns, because the handshake assertions must hold for any stall sequence the ports produce.

// File: rtl/dma_wrap_pkg.sv
package dma_wrap_pkg;

  typedef enum logic [1:0] {
    AM_INC   = 2'b00,
    AM_RSV   = 2'b01,
    AM_FIXED = 2'b10,
    AM_WRAP  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    DIR_M2M = 2'b00,
    DIR_P2M = 2'b01,
    DIR_M2P = 2'b10,
    DIR_RSV = 2'b11
  } xfer_dir_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FETCH = 2'b01,
    ST_STORE = 2'b10
  } seq_state_e;

  localparam int unsigned SEL_HALF_BIT = 2;
  localparam int unsigned SEL_WRAP_BIT = 0;

endpackage

// File: rtl/dma_addr_walker.sv
module dma_addr_walker
  import dma_wrap_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [1:0]    mode,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q, addr_d;
  logic          hold_mode;

  assign hold_mode = (mode == AM_FIXED);

  always_comb begin
    addr_d = addr_q;
    if (clr)                     addr_d = '0;
    else if (load)               addr_d = base;
    else if (step && !hold_mode) addr_d = addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R2: counting modes advance by one per byte
  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !clr && mode != AM_FIXED) |=> addr == $past(addr) + AW'(1));

  // R2: fixed mode keeps its address
  assert_fixed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !clr && mode == AM_FIXED) |=> $stable(addr));

endmodule

// File: rtl/dma_swrst_timer.sv
module dma_swrst_timer #(
  parameter int unsigned HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic active
);

  localparam int unsigned CNTW = $clog2(HOLD + 1);

  logic [CNTW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0) cnt_d = cnt_q - CNTW'(1);
    else if (req)    cnt_d = CNTW'(HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // checking counter: cycles the active level has lasted
  logic [CNTW:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (active) len_q <= len_q + (CNTW+1)'(1);
    else             len_q <= '0;
  end

  // R10: active lasts exactly HOLD cycles
  assert_hold_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> len_q == (CNTW+1)'(HOLD));

  // R10: active only begins from a request
  assert_hold_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(req));

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_wrap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_hit,
  input  logic       wrap_hit,
  input  logic       half_en,
  input  logic       wrap_en,
  input  logic       clr_half,
  input  logic       clr_wrap,
  output logic       half_flag,
  output logic       wrap_flag,
  output logic       irq
);

  logic half_q, half_d, wrap_q, wrap_d;

  always_comb begin
    half_d = (half_q & ~clr_half) | (half_hit & half_en);
    wrap_d = (wrap_q & ~clr_wrap) | (wrap_hit & wrap_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      half_q <= half_d;
      wrap_q <= wrap_d;
    end
  end

  assign half_flag = half_q;
  assign wrap_flag = wrap_q;
  assign irq       = (half_q & half_en) | (wrap_q & wrap_en);

  // R8: a clear with no competing event empties the flag
  assert_clr_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_half && !half_hit) |=> !half_flag);

  assert_clr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wrap && !wrap_hit) |=> !wrap_flag);

endmodule

// File: rtl/dma_wrap_channel.sv
module dma_wrap_channel
  import dma_wrap_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned CW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned SWRST_HOLD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [AW-1:0] cfg_src_base,
  input  logic [AW-1:0] cfg_dst_base,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_dst_mode,
  input  logic [1:0]    cfg_dir,
  input  logic [3:0]    cfg_irq_sel,
  input  logic          swrst_set,
  input  logic          clr_half,
  input  logic          clr_wrap,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  output logic          rd_from_periph,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  output logic          wr_to_periph,
  output logic          busy,
  output logic          done,
  output logic          swrst_active,
  output logic          half_flag,
  output logic          wrap_flag,
  output logic          irq
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, span_q, span_d, cnt_dec;
  logic [DW-1:0] hold_q, hold_d;
  logic          run_wrap_q, run_wrap_d, done_q, done_d, en_q;
  logic          soft_clr, start, rd_fire, store_fire, last_beat;
  logic          cont_wrap, reload, half_hit, wrap_hit, sel_unused;

  assign sel_unused = ^{cfg_irq_sel[3], cfg_irq_sel[1]};

  assign soft_clr   = swrst_set | swrst_active;
  assign start      = cfg_enable & ~en_q & (state_q == ST_IDLE)
                      & (cfg_count != '0) & ~soft_clr;
  assign rd_fire    = (state_q == ST_FETCH) & rd_ready;
  assign store_fire = (state_q == ST_STORE) & cfg_enable & wr_ready;
  assign cnt_dec    = cnt_q - CW'(1);
  assign last_beat  = store_fire & (cnt_dec == '0);
  assign cont_wrap  = run_wrap_q & cfg_enable & (cfg_count != '0);
  assign reload     = last_beat & cont_wrap;
  assign half_hit   = store_fire & run_wrap_q & (span_q >= CW'(2))
                      & (cnt_dec == span_q - (span_q >> 1));
  assign wrap_hit   = last_beat & run_wrap_q;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    span_d     = span_q;
    hold_d     = hold_q;
    run_wrap_d = run_wrap_q;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d    = ST_FETCH;
          cnt_d      = cfg_count;
          span_d     = cfg_count;
          run_wrap_d = (cfg_src_mode == AM_WRAP) || (cfg_dst_mode == AM_WRAP);
        end
      end
      ST_FETCH: begin
        if (rd_fire) begin
          hold_d  = rd_data;
          state_d = cfg_enable ? ST_STORE : ST_IDLE;
        end
      end
      ST_STORE: begin
        if (!cfg_enable) begin
          state_d = ST_IDLE;
        end else if (wr_ready) begin
          if (last_beat) begin
            if (cont_wrap) begin
              cnt_d   = cfg_count;
              span_d  = cfg_count;
              state_d = ST_FETCH;
            end else begin
              cnt_d   = '0;
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end else begin
            cnt_d   = cnt_dec;
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (soft_clr) begin
      state_d    = ST_IDLE;
      cnt_d      = '0;
      span_d     = '0;
      hold_d     = '0;
      run_wrap_d = 1'b0;
      done_d     = 1'b0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      span_q     <= '0;
      hold_q     <= '0;
      run_wrap_q <= 1'b0;
      done_q     <= 1'b0;
      en_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      span_q     <= span_d;
      hold_q     <= hold_d;
      run_wrap_q <= run_wrap_d;
      done_q     <= done_d;
      en_q       <= cfg_enable;
    end
  end

  dma_addr_walker #(.AW(AW)) u_src_walk (
    .clk  (clk),
    .rst_n(rst_ni),
    .clr  (soft_clr),
    .load (start | reload),
    .step (store_fire),
    .base (cfg_src_base),
    .mode (cfg_src_mode),
    .addr (rd_addr)
  );

  dma_addr_walker #(.AW(AW)) u_dst_walk (
    .clk  (clk),
    .rst_n(rst_ni),
    .clr  (soft_clr),
    .load (start | reload),
    .step (store_fire),
    .base (cfg_dst_base),
    .mode (cfg_dst_mode),
    .addr (wr_addr)
  );

  dma_swrst_timer #(.HOLD(SWRST_HOLD)) u_swrst (
    .clk   (clk),
    .rst_n (rst_ni),
    .req   (swrst_set),
    .active(swrst_active)
  );

  dma_irq_flags u_irq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .half_hit (half_hit),
    .wrap_hit (wrap_hit),
    .half_en  (cfg_irq_sel[SEL_HALF_BIT]),
    .wrap_en  (cfg_irq_sel[SEL_WRAP_BIT]),
    .clr_half (clr_half),
    .clr_wrap (clr_wrap),
    .half_flag(half_flag),
    .wrap_flag(wrap_flag),
    .irq      (irq)
  );

  assign rd_valid       = (state_q == ST_FETCH);
  assign wr_valid       = (state_q == ST_STORE) & cfg_enable;
  assign wr_data        = hold_q;
  assign busy           = (state_q != ST_IDLE);
  assign done           = done_q;
  assign rd_from_periph = (cfg_dir == DIR_P2M);
  assign wr_to_periph   = (cfg_dir == DIR_M2P);

  // R4: done comes with the channel at rest
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !busy);

  // R4: done is a single-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  // R7: end-of-pass flag rises only in wrap operation
  assert_wrap_only_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(wrap_flag) |-> $past(run_wrap_q));

  // R3: a waiting read keeps its request and address
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_valid && !rd_ready && !soft_clr) |=> (rd_valid && $stable(rd_addr)));

  // R10: the engine stays idle while soft reset is active
  assert_swrst_idle_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    swrst_active |-> !busy);

endmodule

// File: tb/dma_wrap_channel_bench.sv
module dma_wrap_channel_bench;

  typedef struct packed {
    logic [15:0] sb;
    logic [15:0] db;
    logic [15:0] cnt;
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic [7:0]  rp;
    logic [7:0]  wp;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0100, 16'h0200, 16'd5, 2'b00, 2'b00, 8'hFF,       8'hFF},
    '{16'h0300, 16'h0400, 16'd8, 2'b10, 2'b00, 8'b10110111, 8'b11011011},
    '{16'h0500, 16'h0600, 16'd6, 2'b00, 2'b10, 8'b01101101, 8'hFF},
    '{16'h0700, 16'h0800, 16'd4, 2'b01, 2'b01, 8'hFF,       8'b11001100},
    '{16'hFFFE, 16'h0010, 16'd4, 2'b00, 2'b00, 8'hFF,       8'hFF},
    '{16'h0900, 16'h0A00, 16'd1, 2'b10, 2'b10, 8'b01010101, 8'b10101010}
  };

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable;
  logic [15:0] cfg_src_base, cfg_dst_base, cfg_count;
  logic [1:0]  cfg_src_mode, cfg_dst_mode, cfg_dir;
  logic [3:0]  cfg_irq_sel;
  logic        swrst_set, clr_half, clr_wrap;
  logic        rd_valid, rd_ready, rd_from_periph;
  logic [15:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data;
  logic        wr_valid, wr_ready, wr_to_periph;
  logic        busy, done, swrst_active, half_flag, wrap_flag, irq;

  logic [7:0]  rd_pat = 8'hFF, wr_pat = 8'hFF;
  int          cyc = 0;
  int          nw = 0, ndone = 0;
  logic [15:0] log_a [256];
  logic [7:0]  log_d [256];
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  assign rd_data = src_byte(rd_addr);

  dma_wrap_channel u_dma_wrap_channel (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_count(cfg_count), .cfg_src_mode(cfg_src_mode),
    .cfg_dst_mode(cfg_dst_mode), .cfg_dir(cfg_dir),
    .cfg_irq_sel(cfg_irq_sel), .swrst_set(swrst_set),
    .clr_half(clr_half), .clr_wrap(clr_wrap),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_from_periph(rd_from_periph),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_to_periph(wr_to_periph),
    .busy(busy), .done(done), .swrst_active(swrst_active),
    .half_flag(half_flag), .wrap_flag(wrap_flag), .irq(irq)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    rd_ready = rd_pat[cyc % 8];
    wr_ready = wr_pat[cyc % 8];
  end

  always @(posedge clk) begin
    if (wr_valid && wr_ready) begin
      if (nw < 256) begin
        log_a[nw] = wr_addr;
        log_d[nw] = wr_data;
      end
      nw = nw + 1;
    end
    if (done) ndone = ndone + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_nw(input int n);
    int guard = 0;
    while (nw < n && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic setup(input logic [15:0] sb, db, cnt, input logic [1:0] sm, dm);
    cfg_src_base = sb; cfg_dst_base = db; cfg_count = cnt;
    cfg_src_mode = sm; cfg_dst_mode = dm;
    nw = 0; ndone = 0;
  endtask

  task automatic run_vec(input vec_t v, input int k);
    int guard = 0;
    int miss = 0;
    @(negedge clk);
    setup(v.sb, v.db, v.cnt, v.sm, v.dm);
    cfg_irq_sel = 4'b0101;
    rd_pat = v.rp; wr_pat = v.wp;
    @(negedge clk);
    cfg_enable = 1'b1;
    while (ndone == 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
    chk(nw == int'(v.cnt), "R4", $sformatf("vec%0d byte count", k), nw, v.cnt);
    for (int i = 0; i < int'(v.cnt); i++) begin
      logic [15:0] es, ed;
      es = (v.sm == 2'b10) ? v.sb : 16'(v.sb + i);
      ed = (v.dm == 2'b10) ? v.db : 16'(v.db + i);
      if (log_a[i] != ed || log_d[i] != src_byte(es)) miss++;
    end
    chk(miss == 0, "R2", $sformatf("vec%0d address/data mismatches (R3)", k), miss, 0);
    chk(ndone == 1, "R4", $sformatf("vec%0d done pulses", k), ndone, 1);
    chk(busy == 1'b0, "R4", $sformatf("vec%0d busy after end", k), busy, 0);
    chk(!half_flag && !wrap_flag, "R4", $sformatf("vec%0d flags outside wrap", k),
        {half_flag, wrap_flag}, 0);
    cfg_enable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    int guard;
    rst_n = 1'b0; cfg_enable = 1'b0; swrst_set = 1'b0;
    clr_half = 1'b0; clr_wrap = 1'b0; cfg_dir = 2'b00;
    cfg_irq_sel = 4'b0000;
    setup(16'h0, 16'h0, 16'd1, 2'b00, 2'b00);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(!busy && !done && !rd_valid && !wr_valid, "R1", "idle after reset",
        {busy, done, rd_valid, wr_valid}, 0);
    chk(!irq && !swrst_active, "R1", "irq/swrst after reset", {irq, swrst_active}, 0);

    for (int k = 0; k < NVEC; k++) run_vec(VECS[k], k);

    // R5 R6 R7 R8: wrap operation, count 32
    setup(16'h1000, 16'h2000, 16'd32, 2'b11, 2'b00);
    cfg_irq_sel = 4'b0101; rd_pat = 8'hFF; wr_pat = 8'hFF;
    @(negedge clk);
    cfg_enable = 1'b1;
    wait_nw(15);
    chk(half_flag == 1'b0, "R6", "half flag at 15 of 32", half_flag, 0);
    wait_nw(16);
    chk(half_flag == 1'b1, "R6", "half flag at 16 of 32", half_flag, 1);
    chk(wrap_flag == 1'b0, "R7", "wrap flag at 16 of 32", wrap_flag, 0);
    chk(irq == 1'b1, "R8", "irq from half flag", irq, 1);
    wait_nw(32);
    chk(wrap_flag == 1'b1, "R7", "wrap flag at 32 of 32", wrap_flag, 1);
    chk(busy == 1'b1, "R5", "still busy after pass", busy, 1);
    wait_nw(34);
    chk(log_a[31] == 16'h201F, "R2", "last dst addr of pass", log_a[31], 16'h201F);
    chk(log_a[32] == 16'h2000, "R5", "dst addr reloaded", log_a[32], 16'h2000);
    chk(log_d[32] == src_byte(16'h1000), "R5", "src reloaded", log_d[32], src_byte(16'h1000));
    chk(log_d[33] == src_byte(16'h1001), "R5", "src steps after reload",
        log_d[33], src_byte(16'h1001));
    chk(ndone == 0, "R5", "no done in wrap operation", ndone, 0);
    clr_half = 1'b1; @(negedge clk); clr_half = 1'b0;
    chk(half_flag == 1'b0, "R8", "half cleared", half_flag, 0);
    chk(irq == 1'b1, "R8", "irq held by wrap flag", irq, 1);
    clr_wrap = 1'b1; @(negedge clk); clr_wrap = 1'b0;
    chk(wrap_flag == 1'b0 && irq == 1'b0, "R8", "wrap cleared, irq low",
        {wrap_flag, irq}, 0);
    cfg_irq_sel = 4'b0001;
    wait_nw(50);
    chk(half_flag == 1'b0, "R6", "half not set with select bit 2 clear", half_flag, 0);
    wait_nw(64);
    chk(wrap_flag == 1'b1 && irq == 1'b1, "R7", "wrap flag second pass",
        {wrap_flag, irq}, 3);
    cfg_enable = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy == 1'b0 && ndone == 0, "R9", "wrap stop on disable", {busy, 1'(ndone != 0)}, 0);

    // R9: disable with a captured byte
    setup(16'h3000, 16'h4000, 16'd4, 2'b00, 2'b00);
    wr_pat = 8'h00;
    repeat (2) @(negedge clk);
    cfg_enable = 1'b1;
    guard = 0;
    while (!wr_valid && guard < 100) begin @(negedge clk); guard++; end
    cfg_enable = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9", "idle after drop in store", busy, 0);
    wr_pat = 8'hFF;
    repeat (4) @(negedge clk);
    chk(nw == 0 && ndone == 0, "R9", "held byte dropped", nw, 0);

    // R9 R3: disable with a read waiting
    setup(16'h3100, 16'h4100, 16'd4, 2'b00, 2'b00);
    rd_pat = 8'h00;
    repeat (2) @(negedge clk);
    cfg_enable = 1'b1;
    guard = 0;
    while (!rd_valid && guard < 100) begin @(negedge clk); guard++; end
    chk(rd_addr == 16'h3100, "R3", "first read at base", rd_addr, 16'h3100);
    cfg_enable = 1'b0;
    @(negedge clk);
    chk(rd_valid && busy, "R9", "read held after disable", {rd_valid, busy}, 3);
    @(negedge clk);
    chk(rd_addr == 16'h3100, "R3", "read address stable", rd_addr, 16'h3100);
    rd_pat = 8'hFF;
    repeat (4) @(negedge clk);
    chk(!busy && nw == 0, "R9", "read finished, no write", nw, 0);

    // R10: soft reset in the middle of a wrap run
    setup(16'h5000, 16'h6000, 16'd8, 2'b00, 2'b11);
    cfg_irq_sel = 4'b0101;
    @(negedge clk);
    cfg_enable = 1'b1;
    wait_nw(3);
    swrst_set = 1'b1;
    @(negedge clk);
    swrst_set = 1'b0;
    chk(swrst_active && !busy, "R10", "soft reset cycle 1", {swrst_active, busy}, 2);
    @(negedge clk);
    chk(swrst_active == 1'b1, "R10", "soft reset cycle 2", swrst_active, 1);
    @(negedge clk);
    chk(swrst_active == 1'b1, "R10", "soft reset cycle 3", swrst_active, 1);
    @(negedge clk);
    chk(swrst_active == 1'b0, "R10", "soft reset self-clears", swrst_active, 0);
    n0 = nw;
    repeat (4) @(negedge clk);
    chk(nw == n0 && !busy, "R10", "no restart while enable held", nw, n0);
    cfg_enable = 1'b0;
    @(negedge clk);
    nw = 0;
    cfg_enable = 1'b1;
    wait_nw(2);
    chk(log_a[0] == 16'h6000, "R10", "restart at dst base", log_a[0], 16'h6000);
    chk(log_d[0] == src_byte(16'h5000), "R10", "restart at src base",
        log_d[0], src_byte(16'h5000));
    cfg_enable = 1'b0;
    repeat (4) @(negedge clk);

    // R1: zero count start is ignored
    setup(16'h7000, 16'h7100, 16'd0, 2'b00, 2'b00);
    @(negedge clk);
    cfg_enable = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !rd_valid, "R1", "zero count ignored", {busy, rd_valid}, 0);
    cfg_enable = 1'b0;

    // R11: direction decode
    for (int d = 0; d < 4; d++) begin
      cfg_dir = 2'(d);
      @(negedge clk);
      chk(rd_from_periph == (d == 1) && wr_to_periph == (d == 2), "R11",
          $sformatf("direction code %0d", d), {rd_from_periph, wr_to_periph},
          {1'(d == 1), 1'(d == 2)});
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule